// File: doc/BRIEF.md
# Configuration Address Router with Bridge

This block takes one configuration access at a time, splits its 24-bit address into a bus number, a device/function number and a register offset, and decides where the access belongs. An access can go to a function on the primary segment (bus 0) or to a function on a secondary segment behind a built-in PCI-to-PCI bridge. It can also be answered locally by that bridge's own header. Otherwise it is dropped.

The bridge sits at a fixed device/function on bus 0. Its secondary bus number is programmed at run time by configuration writes to its header, and every later access is decoded against that value. Forwarded accesses appear on a target port, together with a segment flag and the device/function and offset fields. The target returns aligned read data in the same cycle. Absent functions and unmatched buses complete normally. Reads from them return all ones, trimmed to the access width. Every access finishes with a one-cycle completion pulse that carries the read data.

Top module: `cfg_addr_router`

## Requirements
- R1: The access address is split as bus = req_addr[23:16], device/function = req_addr[15:8] (device number in [7:3], function number in [2:0]) and offset = req_addr[7:0]. A forwarded access shows the device/function and offset unchanged on tgt_devfn and tgt_off, and the access size unchanged on tgt_size.
- R2: An access to bus 0 whose device/function is not the bridge's is forwarded with tgt_sec = 0 when pri_present[devfn] is 1.
- R3: An access whose bus equals the programmed secondary bus number, while that number is nonzero, is forwarded with tgt_sec = 1 when sec_present[devfn] is 1.
- R4: An access whose bus is neither 0 nor a nonzero programmed secondary number is dropped. This includes every nonzero bus while the secondary number is 0. A dropped access never raises tgt_valid.
- R5: A read that is dropped, or that targets an absent function, returns all ones masked to its size. req_size encodes 0 = 1 byte (0x000000FF), 1 = 2 bytes (0x0000FFFF), 2 or 3 = 4 bytes (0xFFFFFFFF).
- R6: A write to an absent function or an unmatched bus raises no tgt_valid and changes no state.
- R7: done rises in the cycle after each cycle with req_valid high, for exactly one cycle per request. tgt_valid is only high in such a done cycle. For a forwarded read, rdata is tgt_rdata masked to the size. For any write, rdata is 0.
- R8: The bridge header is served locally. The bridge is at device/function BRIDGE_DEVFN on bus 0, which takes priority over pri_present, and it is never forwarded. Read bytes are little-endian from the offset. Bytes 0..3 hold BRIDGE_ID. Byte 0x0A is 0x04 and byte 0x0B is 0x06 (class 0x0604). Byte 0x0E is 0x81 (multi-function, type 1). Byte 0x19 holds the secondary bus number. All other bytes are 0.
- R9: The secondary bus number resets to 0. A bridge write at offset 0x19 of any size loads it from wdata[7:0]. A bridge write of 2 or more bytes at offset 0x18 loads it from wdata[15:8].
- R10: Any other bridge write leaves the secondary bus number unchanged. This includes a 1-byte write at offset 0x18 and writes at other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 24 | Bus, device/function, offset |
| req_wdata | input | 32 | Write data |
| pri_present | input | 256 | Presence bitmap of primary functions |
| sec_present | input | 256 | Presence bitmap of secondary functions |
| done | output | 1 | Completion pulse |
| rdata | output | 32 | Read data, valid with done |
| tgt_valid | output | 1 | Forwarded access strobe |
| tgt_sec | output | 1 | 0 = primary segment, 1 = secondary |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_size | output | 2 | Forwarded size code |
| tgt_devfn | output | 8 | Forwarded device/function |
| tgt_off | output | 8 | Forwarded register offset |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Read data from the addressed function |

## Verification
Reads are swept over all 256 device/function values on a set of bus numbers: 0, the current secondary number, numbers next to it, and 0xFF. The sweep runs with the secondary number unprogrammed, set by a byte write and set by a halfword write. This separates primary forwarding, secondary forwarding, local bridge decode and dropping, and it shows that an unprogrammed secondary number never claims bus 0 or any other bus. Sizes rotate with the device/function, so the all-ones and truncation masks are each checked against both present and absent functions. Targeted bridge writes tell the loading offsets and sizes apart from the ignored ones. Writes to present and absent functions on both segments show that only real targets see a strobe.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 8;
    localparam int NUM_FN   = 1 << FIELD_W;
    localparam int LANES    = DATA_W / 8;

    localparam logic [FIELD_W-1:0] PRIMARY_BUS  = 8'h00;
    localparam logic [FIELD_W-1:0] SECNUM_OFF   = 8'h19;
    localparam logic [FIELD_W-1:0] SECWIDE_OFF  = 8'h18;
    localparam logic [FIELD_W-1:0] SUBCLASS_OFF = 8'h0A;
    localparam logic [FIELD_W-1:0] BASECLS_OFF  = 8'h0B;
    localparam logic [FIELD_W-1:0] HDRTYPE_OFF  = 8'h0E;
    localparam logic [7:0]         SUBCLASS_VAL = 8'h04;
    localparam logic [7:0]         BASECLS_VAL  = 8'h06;
    localparam logic [7:0]         HDRTYPE_VAL  = 8'h81;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TK_NONE   = 2'd0,
        TK_BRIDGE = 2'd1,
        TK_PRI    = 2'd2,
        TK_SEC    = 2'd3
    } tgt_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] bus;
        logic [FIELD_W-1:0] devfn;
        logic [FIELD_W-1:0] off;
    } cfg_addr_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        acc_size_e         size;
        cfg_addr_t         addr;
        logic [DATA_W-1:0] wdata;
        tgt_kind_e         kind;
    } cfg_stage_t;

    function automatic logic [DATA_W-1:0] size_mask(input acc_size_e s);
        case (s)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] hdr_byte(input logic [FIELD_W-1:0] off,
                                            input logic [DATA_W-1:0]  id,
                                            input logic [7:0]         sec);
        case (off)
            8'h00:        hdr_byte = id[7:0];
            8'h01:        hdr_byte = id[15:8];
            8'h02:        hdr_byte = id[23:16];
            8'h03:        hdr_byte = id[31:24];
            SUBCLASS_OFF: hdr_byte = SUBCLASS_VAL;
            BASECLS_OFF:  hdr_byte = BASECLS_VAL;
            HDRTYPE_OFF:  hdr_byte = HDRTYPE_VAL;
            SECNUM_OFF:   hdr_byte = sec;
            default:      hdr_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_router_pkg::*;
#(
    parameter logic [FIELD_W-1:0] BRIDGE_DEVFN = 8'h08
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] secnum,
    input  logic [NUM_FN-1:0]  pri_present,
    input  logic [NUM_FN-1:0]  sec_present,
    output cfg_addr_t          fields,
    output tgt_kind_e          kind
);

    logic on_primary;
    logic on_secondary;
    logic is_bridge;

    assign fields       = cfg_addr_t'(addr);
    assign on_primary   = (fields.bus == PRIMARY_BUS);
    assign on_secondary = (secnum != PRIMARY_BUS) && (fields.bus == secnum);
    assign is_bridge    = (fields.devfn == BRIDGE_DEVFN);

    always_comb begin
        kind = TK_NONE;
        if (on_primary) begin
            if (is_bridge) begin
                kind = TK_BRIDGE;
            end else if (pri_present[fields.devfn]) begin
                kind = TK_PRI;
            end
        end else if (on_secondary) begin
            if (sec_present[fields.devfn]) begin
                kind = TK_SEC;
            end
        end
    end

endmodule

// File: rtl/cfg_bridge_hdr.sv
module cfg_bridge_hdr
    import cfg_router_pkg::*;
#(
    parameter logic [DATA_W-1:0] BRIDGE_ID = 32'h0001_1B36
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_off,
    input  acc_size_e          wr_size,
    input  logic [15:0]        wr_data,
    input  logic [FIELD_W-1:0] rd_off,
    input  acc_size_e          rd_size,
    output logic [FIELD_W-1:0] secnum,
    output logic [DATA_W-1:0]  rd_data
);

    logic [FIELD_W-1:0] sec_q;
    logic               hit_narrow;
    logic               hit_wide;
    logic [DATA_W-1:0]  raw;

    assign hit_narrow = (wr_off == SECNUM_OFF);
    assign hit_wide   = (wr_off == SECWIDE_OFF) && (wr_size != SZ_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
        end else if (wr_en) begin
            if (hit_narrow) begin
                sec_q <= wr_data[7:0];
            end else if (hit_wide) begin
                sec_q <= wr_data[15:8];
            end
        end
    end

    assign secnum = sec_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign raw[g*8 +: 8] = hdr_byte(rd_off + FIELD_W'(g), BRIDGE_ID, sec_q);
    end

    assign rd_data = raw & size_mask(rd_size);

    // R10
    sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sec_q) |-> $past(wr_en));

    // R9
    sec_wide_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == SECWIDE_OFF && wr_size != SZ_BYTE) |=> (sec_q == $past(wr_data[15:8])));

endmodule

// File: rtl/cfg_resp_stage.sv
module cfg_resp_stage
    import cfg_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  acc_size_e         req_size,
    input  cfg_addr_t         req_fields,
    input  logic [DATA_W-1:0] req_wdata,
    input  tgt_kind_e         req_kind,
    input  logic [DATA_W-1:0] tgt_rdata,
    input  logic [DATA_W-1:0] bridge_rdata,
    output cfg_stage_t        stage,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    cfg_stage_t s_q;
    logic [DATA_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q.valid <= req_valid;
            if (req_valid) begin
                s_q.write <= req_write;
                s_q.size  <= req_size;
                s_q.addr  <= req_fields;
                s_q.wdata <= req_wdata;
                s_q.kind  <= req_kind;
            end
        end
    end

    assign stage = s_q;
    assign done  = s_q.valid;
    assign mask  = size_mask(s_q.size);

    always_comb begin
        rdata = '0;
        if (s_q.valid && !s_q.write) begin
            case (s_q.kind)
                TK_PRI, TK_SEC: rdata = tgt_rdata & mask;
                TK_BRIDGE:      rdata = bridge_rdata;
                default:        rdata = mask;
            endcase
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done);

endmodule

// File: rtl/cfg_addr_router.sv
module cfg_addr_router
    import cfg_router_pkg::*;
#(
    parameter logic [FIELD_W-1:0] BRIDGE_DEVFN = 8'h08,
    parameter logic [DATA_W-1:0]  BRIDGE_ID    = 32'h0001_1B36
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [NUM_FN-1:0]  pri_present,
    input  logic [NUM_FN-1:0]  sec_present,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               tgt_valid,
    output logic               tgt_sec,
    output logic               tgt_write,
    output logic [1:0]         tgt_size,
    output logic [FIELD_W-1:0] tgt_devfn,
    output logic [FIELD_W-1:0] tgt_off,
    output logic [DATA_W-1:0]  tgt_wdata,
    input  logic [DATA_W-1:0]  tgt_rdata
);

    cfg_addr_t          fields;
    tgt_kind_e          kind;
    logic [FIELD_W-1:0] secnum;
    logic [DATA_W-1:0]  bridge_rdata;
    cfg_stage_t         stage;
    acc_size_e          size_in;
    logic               hdr_wr;

    assign size_in = acc_size_e'(req_size);
    assign hdr_wr  = req_valid && req_write && (kind == TK_BRIDGE);

    cfg_addr_decode #(
        .BRIDGE_DEVFN(BRIDGE_DEVFN)
    ) u_decode (
        .addr       (req_addr),
        .secnum     (secnum),
        .pri_present(pri_present),
        .sec_present(sec_present),
        .fields     (fields),
        .kind       (kind)
    );

    cfg_bridge_hdr #(
        .BRIDGE_ID(BRIDGE_ID)
    ) u_bridge (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (hdr_wr),
        .wr_off (fields.off),
        .wr_size(size_in),
        .wr_data(req_wdata[15:0]),
        .rd_off (stage.addr.off),
        .rd_size(stage.size),
        .secnum (secnum),
        .rd_data(bridge_rdata)
    );

    cfg_resp_stage u_resp (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_size    (size_in),
        .req_fields  (fields),
        .req_wdata   (req_wdata),
        .req_kind    (kind),
        .tgt_rdata   (tgt_rdata),
        .bridge_rdata(bridge_rdata),
        .stage       (stage),
        .done        (done),
        .rdata       (rdata)
    );

    assign tgt_valid = stage.valid && (stage.kind == TK_PRI || stage.kind == TK_SEC);
    assign tgt_sec   = (stage.kind == TK_SEC);
    assign tgt_write = stage.write;
    assign tgt_size  = stage.size;
    assign tgt_devfn = stage.addr.devfn;
    assign tgt_off   = stage.addr.off;
    assign tgt_wdata = stage.wdata;

    // R8
    bridge_local_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && !tgt_sec) |-> (tgt_devfn != BRIDGE_DEVFN));

    // R7
    tgt_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> $past(req_valid));

endmodule

// File: tb/test_cfg_addr_router.sv
`timescale 1ns/1ps
module test_cfg_addr_router;

    localparam logic [7:0]  BR_DEVFN = 8'h08;
    localparam logic [31:0] BR_ID    = 32'h0001_1B36;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = 2'd0;
    logic [23:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [255:0] pri_present;
    logic [255:0] sec_present;
    logic         done;
    logic [31:0]  rdata;
    logic         tgt_valid, tgt_sec, tgt_write;
    logic [1:0]   tgt_size;
    logic [7:0]   tgt_devfn, tgt_off;
    logic [31:0]  tgt_wdata, tgt_rdata;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_sec = 8'h00;

    logic        c_done, c_done2, c_tv, c_ts, c_tw;
    logic [31:0] c_rdata, c_twd;
    logic [7:0]  c_tdev, c_toff;
    logic [1:0]  c_tsz;

    always #2 clk = ~clk;

    assign tgt_rdata = {(8'hA0 | {7'd0, tgt_sec}), tgt_devfn, tgt_off, tgt_devfn ^ tgt_off};

    cfg_addr_router #(.BRIDGE_DEVFN(BR_DEVFN), .BRIDGE_ID(BR_ID)) i_cfg_addr_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .pri_present(pri_present), .sec_present(sec_present),
        .done(done), .rdata(rdata), .tgt_valid(tgt_valid), .tgt_sec(tgt_sec),
        .tgt_write(tgt_write), .tgt_size(tgt_size), .tgt_devfn(tgt_devfn),
        .tgt_off(tgt_off), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    // 0 none, 1 bridge, 2 primary, 3 secondary
    function automatic int kind_of(input logic [7:0] bus, input logic [7:0] dv);
        if (bus == 8'h00) begin
            if (dv == BR_DEVFN) return 1;
            return pri_present[dv] ? 2 : 0;
        end
        if (exp_sec != 8'h00 && bus == exp_sec) return sec_present[dv] ? 3 : 0;
        return 0;
    endfunction

    function automatic logic [7:0] hbyte(input logic [7:0] o);
        if (o < 8'h04) return 8'(BR_ID >> (8 * o));
        if (o == 8'h0A) return 8'h04;
        if (o == 8'h0B) return 8'h06;
        if (o == 8'h0E) return 8'h81;
        if (o == 8'h19) return exp_sec;
        return 8'h00;
    endfunction

    function automatic logic [31:0] hword(input logic [7:0] o, input logic [1:0] sz);
        logic [31:0] w;
        w = {hbyte(o + 8'd3), hbyte(o + 8'd2), hbyte(o + 8'd1), hbyte(o)};
        return w & mask_of(sz);
    endfunction

    task automatic acc(input bit wr, input logic [1:0] sz, input logic [7:0] bus,
                       input logic [7:0] dv, input logic [7:0] off, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = {bus, dv, off}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        c_done = done; c_rdata = rdata; c_tv = tgt_valid; c_ts = tgt_sec;
        c_tw = tgt_write; c_tdev = tgt_devfn; c_toff = tgt_off; c_twd = tgt_wdata; c_tsz = tgt_size;
        @(negedge clk);
        c_done2 = done;
    endtask

    task automatic read_chk(input logic [1:0] sz, input logic [7:0] bus, input logic [7:0] dv, input logic [7:0] off);
        int k;
        logic [31:0] exp;
        k = kind_of(bus, dv);
        acc(1'b0, sz, bus, dv, off, 32'h0);
        check(c_done && !c_done2, "R7 done pulse", {30'd0, c_done, c_done2}, 32'h2);
        case (k)
            1: begin
                exp = hword(off, sz);
                check(c_rdata == exp && !c_tv, "R8 bridge header", c_rdata, exp);
            end
            2, 3: begin
                exp = {(8'hA0 | ((k == 3) ? 8'h01 : 8'h00)), dv, off, dv ^ off} & mask_of(sz);
                check(c_tv && c_ts == (k == 3), (k == 3) ? "R3 secondary route" : "R2 primary route",
                      {31'd0, c_ts}, (k == 3) ? 32'd1 : 32'd0);
                check(c_tdev == dv && c_toff == off && c_tsz == sz, "R1 field split",
                      {c_tsz, 6'd0, c_tdev, c_toff}, {sz, 6'd0, dv, off});
                check(c_rdata == exp, "R7 forwarded read data", c_rdata, exp);
            end
            default: begin
                exp = mask_of(sz);
                check(!c_tv, "R4 dropped no strobe", {31'd0, c_tv}, 32'd0);
                check(c_rdata == exp, "R5 all ones", c_rdata, exp);
            end
        endcase
    endtask

    task automatic sec_chk(input string req);
        acc(1'b0, 2'd2, 8'h00, BR_DEVFN, 8'h18, 32'h0);
        check(c_rdata == {16'd0, exp_sec, 8'd0}, req, c_rdata, {16'd0, exp_sec, 8'd0});
    endtask

    task automatic sweep;
        logic [7:0] buses [7];
        buses[0] = 8'h00; buses[1] = 8'h01; buses[2] = exp_sec; buses[3] = exp_sec + 8'd1;
        buses[4] = exp_sec - 8'd1; buses[5] = 8'hFF; buses[6] = 8'h10;
        for (int b = 0; b < 7; b++) begin
            for (int d = 0; d < 256; d++) begin
                read_chk(2'(d % 3), buses[b], 8'(d), 8'((d * 4 + (d >> 2)) & 255));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int d = 0; d < 256; d++) begin
            pri_present[d] = (d % 3 == 1) || (d == int'(BR_DEVFN));
            sec_present[d] = (d % 5 == 2);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && !tgt_valid, "R7 reset idle", {30'd0, done, tgt_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!done, "R7 idle after reset", {31'd0, done}, 32'd0);

        sec_chk("R9 reset secondary number");
        read_chk(2'd2, 8'h00, BR_DEVFN, 8'h00);
        read_chk(2'd2, 8'h00, BR_DEVFN, 8'h08);
        read_chk(2'd2, 8'h00, BR_DEVFN, 8'h0C);
        read_chk(2'd1, 8'h00, BR_DEVFN, 8'h0A);
        read_chk(2'd0, 8'h00, BR_DEVFN, 8'h0E);

        sweep();

        acc(1'b1, 2'd0, 8'h00, BR_DEVFN, 8'h19, 32'hABCD_EF03);
        check(c_rdata == 32'd0 && !c_tv, "R7 write rdata zero", c_rdata, 32'd0);
        exp_sec = 8'h03;
        sec_chk("R9 byte write at 0x19");
        sweep();

        acc(1'b1, 2'd1, 8'h00, BR_DEVFN, 8'h18, 32'h0000_1122);
        exp_sec = 8'h11;
        sec_chk("R9 halfword write at 0x18");
        sweep();

        acc(1'b1, 2'd0, 8'h00, BR_DEVFN, 8'h18, 32'h0000_5555);
        sec_chk("R10 byte write at 0x18 ignored");
        acc(1'b1, 2'd2, 8'h00, BR_DEVFN, 8'h1C, 32'h0000_7777);
        sec_chk("R10 write at 0x1C ignored");
        acc(1'b1, 2'd2, 8'h00, BR_DEVFN, 8'h18, 32'h0000_2200);
        exp_sec = 8'h22;
        sec_chk("R9 word write at 0x18");
        acc(1'b1, 2'd2, 8'h00, BR_DEVFN, 8'h19, 32'h0000_0044);
        exp_sec = 8'h44;
        sec_chk("R9 word write at 0x19");

        acc(1'b1, 2'd2, 8'h00, 8'h04, 8'h40, 32'hDEAD_BEEF);
        check(c_tv && c_tw && !c_ts && c_twd == 32'hDEAD_BEEF, "R2 primary write forwarded", c_twd, 32'hDEAD_BEEF);
        acc(1'b1, 2'd2, 8'h00, 8'h05, 8'h40, 32'h1);
        check(!c_tv, "R6 absent primary write", {31'd0, c_tv}, 32'd0);
        acc(1'b1, 2'd1, 8'h44, 8'h07, 8'h10, 32'h0000_CAFE);
        check(c_tv && c_tw && c_ts && c_twd == 32'h0000_CAFE, "R3 secondary write forwarded", c_twd, 32'h0000_CAFE);
        acc(1'b1, 2'd1, 8'h44, 8'h08, 8'h10, 32'h2);
        check(!c_tv, "R6 absent secondary write", {31'd0, c_tv}, 32'd0);
        acc(1'b1, 2'd2, 8'h45, 8'h07, 8'h19, 32'h0000_0099);
        check(!c_tv, "R6 unmatched bus write", {31'd0, c_tv}, 32'd0);
        sec_chk("R6 unmatched write no state change");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule